// File: doc/BRIEF.md
# Capture Source Selector with Copy-Status Gate

This block decides, frame by frame, which stereo source feeds the capture stream sent to the host. One source is the local ADC. The other is the decoded digital audio receiver. The receiver is used only when three things hold: it reports lock, that lock has held without a break for one whole channel-status block, and the copy-control bits from the receiver's channel status mark the material as original. In every other case the ADC is used. Both sources present one stereo frame together on a shared frame strobe, so each source decision applies to a whole frame.

After the source is chosen, the block applies the format requested by the host. The host may ask for 16-bit stereo or for one of two single-step reductions: mono, or 8-bit samples. A request for both reductions at once is refused. The block raises an error flag and falls back to ADC data in 16-bit stereo.

Top module: `rec_src_sel`

## Requirements
- R1: While reset is held, and on the first sample after it, `out_valid`, `out_src_rx`, `fmt_err`, `out_left` and `out_right` are all zero.
- R2: Each cycle with `frm_valid` high produces exactly one `out_valid` pulse, on the next cycle, and `out_valid` is low on every other cycle.
- R3: A frame presented while `rx_lock` is low is taken from the ADC inputs.
- R4: A count of locked frames is cleared on any cycle where `rx_lock` is low. The receiver can be chosen only once 192 frames (one block) have been counted. That is, the 193rd frame after the most recent loss of lock, or after reset, is the first frame that can come from the receiver.
- R5: The copy status is latched on each frame that has both `rx_lock` and `rx_blk_start` high. It counts as original when `rx_copy_ok` is 1 or `rx_cat_l` is 1. A frame uses the status latched by an earlier frame. If the latched status is not original, the ADC is used. After reset the latched status is not original.
- R6: The format code `fmt_sel` works as follows. 0 passes 16-bit stereo. 1 gives mono: `out_left` is the sum of left and right in 17 bits, shifted right arithmetically by one, and `out_right` is 0. 2 gives 8-bit: each channel carries the upper byte of its sample in bits [7:0], and bits [15:8] are zero.
- R7: For code 3, `fmt_err` is high one cycle after that code is sampled. Any frame taken during that time comes from the ADC and is passed as 16-bit stereo.
- R8: On cycles without `out_valid`, `out_left`, `out_right` and `out_src_rx` keep their values. A change of format code or source conditions affects only the next frame.
- R9: `out_src_rx` is 1 exactly for output frames whose data came from the receiver.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_valid | input | 1 | One stereo frame is present on both sources |
| adc_left | input | 16 | ADC left sample, two's complement |
| adc_right | input | 16 | ADC right sample, two's complement |
| rx_left | input | 16 | Receiver left sample, two's complement |
| rx_right | input | 16 | Receiver right sample, two's complement |
| rx_lock | input | 1 | Receiver lock status |
| rx_blk_start | input | 1 | This frame starts a channel-status block |
| rx_copy_ok | input | 1 | Copy-permit bit from channel status |
| rx_cat_l | input | 1 | Category generation bit; 1 means original |
| fmt_sel | input | 2 | Host format code (see R6, R7) |
| out_valid | output | 1 | Output frame strobe |
| out_left | output | 16 | Left, or mono, output sample |
| out_right | output | 16 | Right output sample |
| out_src_rx | output | 1 | Output frame came from the receiver |
| fmt_err | output | 1 | Disallowed format combination requested |

## Verification
Every result is due one clock after the edge that samples the stimulus. An output frame and its source flag follow a strobed frame by one cycle. The error flag follows the format code by one cycle. The lock-qualification count changes the source decision starting with the frame after the 192nd counted one. The reference model updates on the same rising edge as the design, and the comparison runs on the falling edge that follows, so each expected value is checked in exactly the cycle it is due. Named checks sit on the frames at each boundary: the 192nd and 193rd locked frames, and the frame after each block start.

// File: rtl/rec_pkg.sv
package rec_pkg;
    typedef enum logic [1:0] {
        FMT_STEREO_WIDE = 2'd0,
        FMT_MONO_WIDE   = 2'd1,
        FMT_STEREO_NARR = 2'd2,
        FMT_BAD_COMBO   = 2'd3
    } rec_fmt_e;
endpackage

// File: rtl/rec_lock_qual.sv
module rec_lock_qual #(
    parameter int BLOCK_FRAMES = 192
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frm_valid,
    input  logic rx_lock,
    input  logic rx_blk_start,
    input  logic rx_copy_ok,
    input  logic rx_cat_l,
    output logic qualified,
    output logic original
);
    localparam int CW = $clog2(BLOCK_FRAMES + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(BLOCK_FRAMES);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          orig;
    } qual_t;

    qual_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!rx_lock) begin
            st_d.cnt = '0;
        end else if (frm_valid && (st_q.cnt != CNT_MAX)) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        if (frm_valid && rx_lock && rx_blk_start) begin
            st_d.orig = rx_copy_ok | rx_cat_l;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign qualified = (st_q.cnt == CNT_MAX);
    assign original  = st_q.orig;

    // R4: the count never runs past one block
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_MAX);

    // R4: a lock drop removes qualification on the next cycle
    p_lock_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_lock |=> !qualified);

    // R5: copy status follows the block-start frame
    p_orig_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && rx_lock && rx_blk_start) |=> (original == $past(rx_copy_ok || rx_cat_l)));
endmodule

// File: rtl/rec_fmt_reduce.sv
module rec_fmt_reduce
    import rec_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int NARROW_W = 8
) (
    input  logic [1:0]          fmt,
    input  logic [SAMPLE_W-1:0] in_l,
    input  logic [SAMPLE_W-1:0] in_r,
    output logic [SAMPLE_W-1:0] out_l,
    output logic [SAMPLE_W-1:0] out_r
);
    localparam int SUM_W = SAMPLE_W + 1;
    localparam int PAD_W = SAMPLE_W - NARROW_W;

    logic [SUM_W-1:0] sum;

    assign sum = {in_l[SAMPLE_W-1], in_l} + {in_r[SAMPLE_W-1], in_r};

    always_comb begin
        out_l = in_l;
        out_r = in_r;
        case (fmt)
            FMT_MONO_WIDE: begin
                out_l = sum[SUM_W-1:1];
                out_r = '0;
            end
            FMT_STEREO_NARR: begin
                out_l = {{PAD_W{1'b0}}, in_l[SAMPLE_W-1 -: NARROW_W]};
                out_r = {{PAD_W{1'b0}}, in_r[SAMPLE_W-1 -: NARROW_W]};
            end
            default: begin
                out_l = in_l;
                out_r = in_r;
            end
        endcase
    end
endmodule

// File: rtl/rec_src_sel.sv
module rec_src_sel
    import rec_pkg::*;
#(
    parameter int SAMPLE_W     = 16,
    parameter int NARROW_W     = 8,
    parameter int BLOCK_FRAMES = 192
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frm_valid,
    input  logic [SAMPLE_W-1:0] adc_left,
    input  logic [SAMPLE_W-1:0] adc_right,
    input  logic [SAMPLE_W-1:0] rx_left,
    input  logic [SAMPLE_W-1:0] rx_right,
    input  logic                rx_lock,
    input  logic                rx_blk_start,
    input  logic                rx_copy_ok,
    input  logic                rx_cat_l,
    input  logic [1:0]          fmt_sel,
    output logic                out_valid,
    output logic [SAMPLE_W-1:0] out_left,
    output logic [SAMPLE_W-1:0] out_right,
    output logic                out_src_rx,
    output logic                fmt_err
);
    typedef struct packed {
        logic                valid;
        logic                src_rx;
        logic                err;
        logic [SAMPLE_W-1:0] l;
        logic [SAMPLE_W-1:0] r;
    } out_t;

    out_t st_d, st_q;

    logic                qualified;
    logic                original;
    logic                bad_fmt;
    logic                use_rx;
    logic [SAMPLE_W-1:0] pick_l, pick_r;
    logic [SAMPLE_W-1:0] red_l, red_r;

    rec_lock_qual #(
        .BLOCK_FRAMES(BLOCK_FRAMES)
    ) u_qual (
        .clk          (clk),
        .rst_n        (rst_n),
        .frm_valid    (frm_valid),
        .rx_lock      (rx_lock),
        .rx_blk_start (rx_blk_start),
        .rx_copy_ok   (rx_copy_ok),
        .rx_cat_l     (rx_cat_l),
        .qualified    (qualified),
        .original     (original)
    );

    assign bad_fmt = (fmt_sel == FMT_BAD_COMBO);
    assign use_rx  = rx_lock && qualified && original && !bad_fmt;
    assign pick_l  = use_rx ? rx_left  : adc_left;
    assign pick_r  = use_rx ? rx_right : adc_right;

    rec_fmt_reduce #(
        .SAMPLE_W (SAMPLE_W),
        .NARROW_W (NARROW_W)
    ) u_reduce (
        .fmt   (fmt_sel),
        .in_l  (pick_l),
        .in_r  (pick_r),
        .out_l (red_l),
        .out_r (red_r)
    );

    always_comb begin
        st_d       = st_q;
        st_d.err   = bad_fmt;
        st_d.valid = frm_valid;
        if (frm_valid) begin
            st_d.src_rx = use_rx;
            st_d.l      = red_l;
            st_d.r      = red_r;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid  = st_q.valid;
    assign out_src_rx = st_q.src_rx;
    assign fmt_err    = st_q.err;
    assign out_left   = st_q.l;
    assign out_right  = st_q.r;

    // R3: receiver frames only come from a locked input
    p_rx_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_src_rx) |-> $past(rx_lock));

    // R4: receiver frames only after one full qualified block
    p_rx_qualified_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_src_rx) |-> $past(qualified));

    // R6: narrow mode leaves the upper bits clear
    p_narrow_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ($past(fmt_sel) == FMT_STEREO_NARR)) |->
            (out_left[SAMPLE_W-1:NARROW_W] == '0 && out_right[SAMPLE_W-1:NARROW_W] == '0));

    // R7: a refused format never forwards receiver data
    p_bad_fmt_adc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && fmt_err) |-> !out_src_rx);

    // R8: outputs hold between frames
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(out_left) && $stable(out_right) && $stable(out_src_rx)));
endmodule

// File: tb/tb_rec_src_sel.sv
module tb_rec_src_sel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frm_valid = 1'b0;
    logic [15:0] adc_left = '0, adc_right = '0, rx_left = '0, rx_right = '0;
    logic        rx_lock = 1'b0, rx_blk_start = 1'b0, rx_copy_ok = 1'b0, rx_cat_l = 1'b0;
    logic [1:0]  fmt_sel = 2'd0;
    logic        out_valid, out_src_rx, fmt_err;
    logic [15:0] out_left, out_right;

    int vectors = 0;
    int miscompares = 0;
    bit checking = 1'b0;

    // reference state
    int          m_cnt = 0;
    bit          m_orig = 1'b0;
    logic        exp_valid = 1'b0, exp_src = 1'b0, exp_err = 1'b0;
    logic [15:0] exp_l = '0, exp_r = '0;
    logic        last_src = 1'b0;
    logic [15:0] last_l = '0, last_r = '0;

    always #4 clk = ~clk;

    rec_src_sel dut (
        .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid),
        .adc_left(adc_left), .adc_right(adc_right),
        .rx_left(rx_left), .rx_right(rx_right),
        .rx_lock(rx_lock), .rx_blk_start(rx_blk_start),
        .rx_copy_ok(rx_copy_ok), .rx_cat_l(rx_cat_l),
        .fmt_sel(fmt_sel),
        .out_valid(out_valid), .out_left(out_left), .out_right(out_right),
        .out_src_rx(out_src_rx), .fmt_err(fmt_err)
    );

    // behavioural reference, advanced on the same edge as the design
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_orig = 0;
            exp_valid = 0; exp_src = 0; exp_err = 0; exp_l = 0; exp_r = 0;
        end else begin
            bit          take_rx;
            logic [15:0] sl, sr;
            int          mean;
            exp_err = (fmt_sel == 2'd3);
            exp_valid = frm_valid;
            if (frm_valid) begin
                take_rx = rx_lock && (m_cnt >= 192) && m_orig && (fmt_sel != 2'd3);
                sl = take_rx ? rx_left : adc_left;
                sr = take_rx ? rx_right : adc_right;
                exp_src = take_rx;
                if (fmt_sel == 2'd1) begin
                    mean = ($signed(sl) + $signed(sr)) >>> 1;
                    exp_l = mean[15:0];
                    exp_r = 16'd0;
                end else if (fmt_sel == 2'd2) begin
                    exp_l = {8'd0, sl[15:8]};
                    exp_r = {8'd0, sr[15:8]};
                end else begin
                    exp_l = sl;
                    exp_r = sr;
                end
            end
            if (!rx_lock) m_cnt = 0;
            else if (frm_valid && m_cnt < 192) m_cnt = m_cnt + 1;
            if (frm_valid && rx_lock && rx_blk_start) m_orig = rx_copy_ok | rx_cat_l;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
        vectors++;
        if (act !== expv) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, expv, $time);
        end
    endtask

    // per-clock comparison, away from the rising edge
    always @(negedge clk) begin
        if (checking) begin
            chk("R2 valid", {31'd0, out_valid}, {31'd0, exp_valid});
            chk("R9 source flag", {31'd0, out_src_rx}, {31'd0, exp_src});
            chk("R7 error flag", {31'd0, fmt_err}, {31'd0, exp_err});
            chk("R6 left data", {16'd0, out_left}, {16'd0, exp_l});
            chk("R6 right data", {16'd0, out_right}, {16'd0, exp_r});
            if (out_valid) begin
                last_src = out_src_rx; last_l = out_left; last_r = out_right;
            end
        end
    end

    task automatic do_frame(input logic lk, input logic blk, input logic cp, input logic cl,
                            input logic [15:0] al, input logic [15:0] ar,
                            input logic [15:0] rl, input logic [15:0] rr);
        frm_valid = 1; rx_lock = lk; rx_blk_start = blk; rx_copy_ok = cp; rx_cat_l = cl;
        adc_left = al; adc_right = ar; rx_left = rl; rx_right = rr;
        @(negedge clk);
        frm_valid = 0; rx_blk_start = 0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 valid", {31'd0, out_valid}, 32'd0);
        chk("R1 src", {31'd0, out_src_rx}, 32'd0);
        chk("R1 err", {31'd0, fmt_err}, 32'd0);
        chk("R1 data", {out_left, out_right}, 32'd0);
        rst_n = 1;
        checking = 1;
        @(negedge clk);

        // R3 unlocked frames come from the ADC
        for (int i = 0; i < 6; i++)
            do_frame(0, 0, 1, 1, 16'(i * 311 + 7), 16'(i * 97 + 3), 16'h1111, 16'h2222);
        chk("R3 adc while unlocked", {31'd0, last_src}, 32'd0);
        chk("R3 adc data", {16'd0, last_l}, {16'd0, 16'(5 * 311 + 7)});

        // R4 lock qualification across one full block
        for (int i = 0; i < 200; i++) begin
            do_frame(1, (i % 192) == 0, 1, 0, 16'(i * 13), 16'(i * 29), 16'(16'h4000 + i), 16'(16'hC000 - i));
            if (i == 191) chk("R4 frame 192 still adc", {31'd0, last_src}, 32'd0);
            if (i == 192) begin
                chk("R4 frame 193 from receiver", {31'd0, last_src}, 32'd1);
                chk("R9 receiver data", {16'd0, last_l}, {16'd0, 16'(16'h4000 + 192)});
            end
        end

        // R6 mono of extremes, then narrow
        fmt_sel = 2'd1;
        do_frame(1, 0, 1, 0, 16'h0001, 16'h0002, 16'h8000, 16'h7FFF);
        chk("R6 mono mean", {16'd0, last_l}, 32'h0000FFFF);
        do_frame(1, 0, 1, 0, 16'h0001, 16'h0002, 16'h7FFF, 16'h7FFF);
        chk("R6 mono positive", {16'd0, last_l}, 32'h00007FFF);
        fmt_sel = 2'd2;
        do_frame(1, 0, 1, 0, 16'h0001, 16'h0002, 16'hA5C3, 16'h3C5A);
        chk("R6 narrow left", {16'd0, last_l}, 32'h000000A5);
        chk("R6 narrow right", {16'd0, last_r}, 32'h0000003C);

        // R7 refused combination
        fmt_sel = 2'd3;
        do_frame(1, 0, 1, 0, 16'h1234, 16'h5678, 16'h9ABC, 16'hDEF0);
        chk("R7 error flag", {31'd0, fmt_err}, 32'd1);
        chk("R7 falls back to adc", {31'd0, last_src}, 32'd0);
        chk("R7 wide stereo adc", {last_l, last_r}, 32'h12345678);

        // R8 format change without a frame leaves outputs alone
        fmt_sel = 2'd1;
        repeat (4) @(negedge clk);
        chk("R8 hold data", {last_l, last_r}, {out_left, out_right});
        chk("R8 hold left value", {16'd0, out_left}, 32'h00001234);
        fmt_sel = 2'd0;
        do_frame(1, 0, 1, 0, 16'h0101, 16'h0202, 16'h0303, 16'h0404);
        chk("R9 back to receiver", {31'd0, last_src}, 32'd1);

        // R4 single-cycle lock drop forces a fresh block
        rx_lock = 0;
        @(negedge clk);
        rx_lock = 1;
        for (int i = 0; i < 193; i++) begin
            do_frame(1, 0, 1, 0, 16'(i + 1), 16'(i + 2), 16'(i + 3), 16'(i + 4));
            if (i == 0) chk("R4 after drop adc", {31'd0, last_src}, 32'd0);
            if (i == 191) chk("R4 relock frame 192 adc", {31'd0, last_src}, 32'd0);
            if (i == 192) chk("R4 relock frame 193 receiver", {31'd0, last_src}, 32'd1);
        end

        // R5 copy status gating
        do_frame(1, 1, 0, 0, 16'h00AA, 16'h00BB, 16'h00CC, 16'h00DD);
        chk("R5 old status still used", {31'd0, last_src}, 32'd1);
        do_frame(1, 0, 1, 1, 16'h00AA, 16'h00BB, 16'h00CC, 16'h00DD);
        chk("R5 not original uses adc", {31'd0, last_src}, 32'd0);
        do_frame(1, 1, 0, 1, 16'h0011, 16'h0022, 16'h0033, 16'h0044);
        do_frame(1, 0, 0, 0, 16'h0011, 16'h0022, 16'h0033, 16'h0044);
        chk("R5 generation bit original", {31'd0, last_src}, 32'd1);

        repeat (3) @(negedge clk);
        checking = 0;
        finish_run();
    end
endmodule